// File: doc/BRIEF.md
# I2C Control Register with Interrupt Gating

This block is the 8-bit control register of a multi-master I2C controller. It sits on a simple CPU register bus and keeps the controller's control settings. These are: a module enable, an interrupt enable, acknowledge suppression, a repeated-start request and a marker that says the next received byte carries the packet error check. A write with the busy-clear bit set is never stored. Instead it sends a one-cycle clear pulse to the status logic, which owns the bus-busy flag.

The block also merges the status flags from the bit engine (transmit done, receive done, arbitration lost, NAK) into one level-sensitive interrupt request. While the module is disabled it tells the status logic to hold its flags at their defaults. Hardware can withdraw the repeated-start request. This happens when the bit engine reports that the repeated START has finished, and when master mode drops. The serial bit engine is not part of this block.

Top module: `i2c_ctrl_reg`

## Requirements
- R1: While and after a synchronous reset, every control output is 0, `busy_clr` and `irq` are 0, and `flags_hold` is 1.
- R2: A write (`wr_en`=1) stores `wr_data` bit 7 as module enable, bit 6 as interrupt enable, bit 3 as acknowledge disable and bit 1 as PEC-byte marker. The new values appear at the outputs and in the read value from the next cycle on.
- R3: In the read value, bit 7 is the module enable, bit 6 the interrupt enable, bit 3 the acknowledge disable, bit 2 the repeated-start bit and bit 1 the PEC marker. Bits 5, 4 and 0 always read 0.
- R4: `irq` is high exactly when module enable and interrupt enable are both 1 and at least one bit of `flags` is 1. The flag positions are: bit 0 transmit, bit 1 receive, bit 2 arbitration lost, bit 3 NAK. With interrupt enable at 0, no flag raises `irq`.
- R5: A write with `wr_data` bit 5 = 1 drives `busy_clr` high for exactly the next cycle. A write with bit 5 = 0 gives no pulse, and the bit is never stored.
- R6: `flags_hold` is the inverse of the stored module enable, and `irq` stays 0 while the module is disabled.
- R7: A write loads `wr_data` bit 2 into the repeated-start bit. `rstart_req` is high only while that bit and `master_mode` are both 1.
- R8: The repeated-start bit reads 0 in the cycle after `rstart_done` is high. It also reads 0 in the cycle after `master_mode` goes from 1 to 0.
- R9: If a write that sets the repeated-start bit happens in the same cycle as either hardware clear event, the bit ends up 0.
- R10: `rd_data` is 0 whenever `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, 0 when not reading |
| flags | input | 4 | Status flags: tx, rx, arbitration lost, NAK |
| rstart_done | input | 1 | Pulse: repeated START completed |
| master_mode | input | 1 | Master mode level from the status logic |
| mod_en | output | 1 | Module enable |
| irq_en | output | 1 | Interrupt enable |
| ack_off | output | 1 | Suppress acknowledge on the 9th clock |
| pec_next | output | 1 | Next received byte is the PEC byte |
| rstart_req | output | 1 | Repeated START request, qualified by master mode |
| busy_clr | output | 1 | One-cycle clear pulse for the bus-busy flag |
| flags_hold | output | 1 | Hold the status flags at their defaults |
| irq | output | 1 | Interrupt request level |

## Verification
The hardest case to reach is a collision: a software write that sets the repeated-start bit in the same cycle as a hardware clear event. The clear event can be a completion pulse or a falling edge of master mode. Directed steps place the write in exactly the same cycle as each of the two clear events. After that, a long random phase toggles master mode, completion pulses and writes independently, so the collisions also occur in mixed combinations. A cycle-accurate model in the bench predicts every output on every clock.

// File: rtl/i2c_cr_pkg.sv
package i2c_cr_pkg;

    localparam int CR_W      = 8;
    localparam int NUM_FLAGS = 4;

    localparam int BIT_EN    = 7;
    localparam int BIT_IE    = 6;
    localparam int BIT_BCLR  = 5;
    localparam int BIT_ACK   = 3;
    localparam int BIT_RS    = 2;
    localparam int BIT_PEC   = 1;

    typedef struct packed {
        logic en;
        logic ie;
        logic ack_off;
        logic rs;
        logic pec;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '0;

    typedef enum logic [1:0] {
        RS_KEEP,
        RS_LOAD,
        RS_HWCLR
    } rs_act_e;

    function automatic ctrl_t decode_wr(input logic [CR_W-1:0] d);
        ctrl_t c;
        c.en      = d[BIT_EN];
        c.ie      = d[BIT_IE];
        c.ack_off = d[BIT_ACK];
        c.rs      = d[BIT_RS];
        c.pec     = d[BIT_PEC];
        return c;
    endfunction

    function automatic logic [CR_W-1:0] encode_rd(input ctrl_t c);
        logic [CR_W-1:0] v;
        v          = '0;
        v[BIT_EN]  = c.en;
        v[BIT_IE]  = c.ie;
        v[BIT_ACK] = c.ack_off;
        v[BIT_RS]  = c.rs;
        v[BIT_PEC] = c.pec;
        return v;
    endfunction

endpackage

// File: rtl/i2c_cr_store.sv
module i2c_cr_store
    import i2c_cr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  ctrl_t wr_ctrl,
    input  logic  rstart_done,
    input  logic  master_mode,
    output ctrl_t ctrl
);

    ctrl_t   ctrl_q;
    ctrl_t   ctrl_d;
    logic    mst_q;
    logic    hw_clr;
    rs_act_e rs_act;

    // master_mode is tracked even during reset so that edge detection is
    // consistent on the first cycle after reset
    always_ff @(posedge clk) begin
        mst_q <= master_mode;
    end

    assign hw_clr = rstart_done | (mst_q & ~master_mode);

    always_comb begin
        if (hw_clr)
            rs_act = RS_HWCLR;
        else if (wr_en)
            rs_act = RS_LOAD;
        else
            rs_act = RS_KEEP;
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.en      = wr_ctrl.en;
            ctrl_d.ie      = wr_ctrl.ie;
            ctrl_d.ack_off = wr_ctrl.ack_off;
            ctrl_d.pec     = wr_ctrl.pec;
        end
        case (rs_act)
            RS_LOAD:  ctrl_d.rs = wr_ctrl.rs;
            RS_HWCLR: ctrl_d.rs = 1'b0;
            default:  ctrl_d.rs = ctrl_q.rs;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= CTRL_RST;
        else
            ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;

    AST_WRITE_STORES: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctrl.en == $past(wr_ctrl.en)) && (ctrl.pec == $past(wr_ctrl.pec))); // R2
    AST_DONE_CLEARS_RS: assert property (@(posedge clk) disable iff (rst)
        rstart_done |=> !ctrl.rs); // R8
    AST_MST_DROP_CLEARS_RS: assert property (@(posedge clk) disable iff (rst)
        $fell(master_mode) |=> !ctrl.rs); // R8
    AST_HW_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ctrl.rs && rstart_done) |=> !ctrl.rs); // R9

endmodule

// File: rtl/i2c_cr_strobe.sv
module i2c_cr_strobe (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic bclr_bit,
    input  logic en,
    output logic busy_clr,
    output logic flags_hold
);

    logic pulse_q;

    always_ff @(posedge clk) begin
        if (rst)
            pulse_q <= 1'b0;
        else
            pulse_q <= wr_en & bclr_bit;
    end

    assign busy_clr   = pulse_q;
    assign flags_hold = ~en;

    AST_BCLR_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        busy_clr |-> $past(wr_en && bclr_bit)); // R5
    AST_BCLR_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !busy_clr); // R5

endmodule

// File: rtl/i2c_cr_irq.sv
module i2c_cr_irq #(
    parameter int N = 4
) (
    input  logic [N-1:0] flags,
    input  logic         en,
    input  logic         ie,
    output logic         irq
);

    localparam int LAST = N - 1;

    logic         gate;
    logic [N-1:0] masked;

    assign gate = en & ie;

    for (genvar i = 0; i <= LAST; i++) begin : g_mask
        assign masked[i] = flags[i] & gate;
    end

    assign irq = |masked;

endmodule

// File: rtl/i2c_ctrl_reg.sv
module i2c_ctrl_reg
    import i2c_cr_pkg::*;
#(
    parameter int NFLAG = NUM_FLAGS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [CR_W-1:0]  wr_data,
    output logic [CR_W-1:0]  rd_data,
    input  logic [NFLAG-1:0] flags,
    input  logic             rstart_done,
    input  logic             master_mode,
    output logic             mod_en,
    output logic             irq_en,
    output logic             ack_off,
    output logic             pec_next,
    output logic             rstart_req,
    output logic             busy_clr,
    output logic             flags_hold,
    output logic             irq
);

    ctrl_t wr_ctrl;
    ctrl_t ctrl;
    logic  unused_wr_bits;

    assign wr_ctrl        = decode_wr(wr_data);
    assign unused_wr_bits = ^{wr_data[4], wr_data[0]};

    i2c_cr_store u_store (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_ctrl     (wr_ctrl),
        .rstart_done (rstart_done),
        .master_mode (master_mode),
        .ctrl        (ctrl)
    );

    i2c_cr_strobe u_strobe (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .bclr_bit   (wr_data[BIT_BCLR]),
        .en         (ctrl.en),
        .busy_clr   (busy_clr),
        .flags_hold (flags_hold)
    );

    i2c_cr_irq #(.N(NFLAG)) u_irq (
        .flags (flags),
        .en    (ctrl.en),
        .ie    (ctrl.ie),
        .irq   (irq)
    );

    assign mod_en     = ctrl.en;
    assign irq_en     = ctrl.ie;
    assign ack_off    = ctrl.ack_off;
    assign pec_next   = ctrl.pec;
    assign rstart_req = ctrl.rs & master_mode;
    assign rd_data    = rd_en ? encode_rd(ctrl) : '0;

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !(irq_en && mod_en) |-> !irq); // R4 R6
    AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (rst)
        (irq_en && mod_en && (|flags)) |-> irq); // R4
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_data[5] == 1'b0) && (rd_data[4] == 1'b0) && (rd_data[0] == 1'b0)); // R3
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == '0)); // R10
    AST_RSREQ_MASTER: assert property (@(posedge clk) disable iff (rst)
        rstart_req |-> master_mode); // R7
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !mod_en |-> flags_hold); // R6

endmodule

// File: tb/i2c_ctrl_reg_bench.sv
module i2c_ctrl_reg_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [3:0] flags = 4'h0;
    logic       rstart_done = 1'b0;
    logic       master_mode = 1'b0;
    logic       mod_en, irq_en, ack_off, pec_next, rstart_req;
    logic       busy_clr, flags_hold, irq;

    int compared = 0;
    int mismatched = 0;
    bit started = 0;
    bit done = 0;

    // reference model state
    bit m_en, m_ie, m_ack, m_rs, m_pec, m_bc, m_mst;

    always #4 clk = ~clk;

    i2c_ctrl_reg u_i2c_ctrl_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .flags(flags),
        .rstart_done(rstart_done), .master_mode(master_mode),
        .mod_en(mod_en), .irq_en(irq_en), .ack_off(ack_off),
        .pec_next(pec_next), .rstart_req(rstart_req),
        .busy_clr(busy_clr), .flags_hold(flags_hold), .irq(irq)
    );

    always @(posedge clk) begin
        bit clr;
        started = 1;
        if (rst) begin
            m_en = 0; m_ie = 0; m_ack = 0; m_rs = 0; m_pec = 0; m_bc = 0;
        end else begin
            clr = rstart_done || (m_mst && !master_mode);
            if (wr_en) begin
                m_en = wr_data[7]; m_ie = wr_data[6];
                m_ack = wr_data[3]; m_pec = wr_data[1];
                m_rs = clr ? 1'b0 : wr_data[2];
            end else if (clr) begin
                m_rs = 0;
            end
            m_bc = wr_en && wr_data[5];
        end
        m_mst = master_mode;
    end

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk("R1 R2 mod_en", mod_en, m_en);
            chk("R2 irq_en", irq_en, m_ie);
            chk("R2 ack_off", ack_off, m_ack);
            chk("R2 pec_next", pec_next, m_pec);
            chk("R7 R8 R9 rstart_req", rstart_req, m_rs && master_mode);
            chk("R5 busy_clr", busy_clr, m_bc);
            chk("R1 R6 flags_hold", flags_hold, !m_en);
            chk("R4 R6 irq", irq, m_en && m_ie && (flags != 0));
            chk("R3 R10 rd_data", rd_data,
                rd_en ? {m_en, m_ie, 2'b00, m_ack, m_rs, m_pec, 1'b0} : 8'h00);
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1; wr_data = d;
        cyc();
        wr_en = 0; wr_data = 8'h00;
    endtask

    initial begin
        #(8 * 200000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        rd_en = 1;
        repeat (3) cyc();
        @(negedge clk);
        chk("R1 reset read", rd_data, 8'h00);
        chk("R1 reset hold", flags_hold, 1);
        @(posedge clk); #2;
        rst = 0;
        cyc();
        // R2 R3: full and alternating patterns
        wr(8'hFF); cyc();
        wr(8'hAA); cyc();
        wr(8'h55); cyc();
        @(negedge clk);
        chk("R3 reserved bits", {29'd0, rd_data[5], rd_data[4], rd_data[0]}, 0);
        cyc();
        // R10 read idle
        rd_en = 0; cyc(); cyc(); rd_en = 1;
        // R4 interrupt with ie=1 and each flag
        wr(8'hC0);
        for (int i = 0; i < 4; i++) begin
            flags = 4'(1 << i); cyc();
        end
        flags = 4'hF; cyc();
        @(negedge clk); chk("R4 irq with flags", irq, 1);
        flags = 0; cyc();
        // R4 ie=0 no request
        wr(8'h80); flags = 4'hF; cyc();
        @(negedge clk); chk("R4 irq masked", irq, 0);
        // R6 disabled
        wr(8'h40); cyc();
        @(negedge clk); chk("R6 irq disabled", irq, 0);
        flags = 0;
        // R5 busy clear
        wr(8'h20);
        @(negedge clk); chk("R5 pulse", busy_clr, 1);
        cyc();
        @(negedge clk); chk("R5 pulse one cycle", busy_clr, 0);
        chk("R5 not stored", rd_data, 8'h00);
        wr(8'h00); cyc();
        // R7 R8 rstart_done
        master_mode = 1; cyc();
        wr(8'h84); cyc();
        @(negedge clk); chk("R7 rstart_req", rstart_req, 1);
        rstart_done = 1; cyc(); rstart_done = 0;
        @(negedge clk); chk("R8 done clears", rd_data[2], 0);
        // R8 master drop
        wr(8'h84); cyc();
        master_mode = 0; cyc();
        @(negedge clk); chk("R8 master drop clears", rd_data[2], 0);
        // R9 collisions
        master_mode = 1; cyc();
        rstart_done = 1; wr(8'h84); rstart_done = 0;
        @(negedge clk); chk("R9 done wins", rd_data[2], 0);
        cyc();
        master_mode = 0; wr(8'h84);
        @(negedge clk); chk("R9 drop wins", rd_data[2], 0);
        cyc();
        // random phase
        for (int n = 0; n < 2000; n++) begin
            wr_en = ($urandom % 3) == 0;
            wr_data = 8'($urandom);
            rd_en = ($urandom % 4) != 0;
            flags = 4'($urandom);
            rstart_done = ($urandom % 5) == 0;
            if (($urandom % 4) == 0) master_mode = ~master_mode;
            if (n == 1000) rst = 1;
            if (n == 1003) rst = 0;
            cyc();
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule